// File: doc/BRIEF.md
# Video Timing Reference Decoder

This block sits on a byte-wide digital video stream of the interleaved 4:2:2 kind and finds the timing reference codes embedded in it. A code is a three-byte preamble (FF, 00, 00) followed by a status byte. The status byte carries the field, vertical-blanking and horizontal-position flags and four protection bits. The decoder checks the status byte, keeps the last good flags, and reports each start-of-video and end-of-video code as a one-cycle pulse. When a status byte fails its check, the decoder raises an error pulse instead.

Between a start-of-video code on a picture line and the next preamble, every enabled byte is marked as active picture data. Each such byte is tagged as a blue-difference, luma or red-difference sample and numbered from zero. A clock enable qualifies each input byte, so the stream can run at any fraction of the clock rate.

The control is one state machine with five named states. ST_HUNT waits in blanking for FF. ST_GOT_FF has seen FF. ST_GOT_Z1 has seen FF 00. ST_GOT_Z2 has seen FF 00 00, so the next byte is the status byte. ST_ACTIVE passes picture bytes. All transitions happen only on enabled bytes:
- HUNT→GOT_FF on FF.
- ACTIVE→GOT_FF on FF. Any other byte keeps ACTIVE and is counted as picture data.
- GOT_FF→GOT_Z1 and GOT_Z1→GOT_Z2 on 00. On FF, both states return to GOT_FF. On any other byte, both states return to HUNT.
- GOT_Z2→ACTIVE on a good start code whose blanking flag is 0. GOT_Z2→HUNT on every other status byte.

Top module: `trs_stream_decoder`

## Requirements
- R1: During and straight after reset, field_o=0, vblank_o=1, hpos_o=1, line_valid_o=0, and active_o, sav_o, eav_o and prot_err_o are all 0.
- R2: A status byte is only decoded when it is the enabled byte immediately after the enabled bytes FF, 00, 00. Extra FF bytes before the 00 pair restart the preamble. A preamble broken by any other byte produces no decode: no pulse and no flag change.
- R3: A status byte is good when bit 7 is 1 and bits 3..0 equal {V^H, F^H, F^V, F^V^H}, where F=bit 6, V=bit 5 and H=bit 4. One cycle after a good status byte, field_o=F, vblank_o=V and hpos_o=H.
- R4: One cycle after a status byte that is not good, prot_err_o is high for exactly one cycle. In that case field_o, vblank_o, hpos_o and line_valid_o keep their previous values, and neither sav_o nor eav_o pulses.
- R5: One cycle after a good status byte, sav_o pulses for one cycle if H=0, and eav_o pulses for one cycle if H=1.
- R6: line_valid_o becomes 1 after a good code with H=0 and V=0. It becomes 0 after a good code with H=1, and after a good code with H=0 and V=1.
- R7: After a good H=0, V=0 code, active_o is 1 in the cycle after each enabled byte other than FF. The first FF ends the active run, and that FF byte is not marked active. active_o stays 0 after codes with V=1, after bad codes, and in blanking.
- R8: When active_o=1, comp_o tags the byte: 0=Cb, 1=Y, 2=Cr. The tags run Cb, Y, Cr, Y repeatedly, starting at Cb on the first byte after each start code. byte_idx_o gives the byte number, starting at 0.
- R9: A cycle with en=0 changes no state. In the cycle after it, active_o, sav_o, eav_o and prot_err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Qualifies din for this cycle |
| din | input | 8 | Video stream byte |
| field_o | output | 1 | Last good field flag |
| vblank_o | output | 1 | Last good vertical-blanking flag |
| hpos_o | output | 1 | Last good horizontal-position flag (1 = end code) |
| line_valid_o | output | 1 | Current line carries picture data |
| sav_o | output | 1 | Start-of-video code pulse |
| eav_o | output | 1 | End-of-video code pulse |
| prot_err_o | output | 1 | Bad status byte pulse |
| active_o | output | 1 | Previous enabled byte was active picture data |
| comp_o | output | 2 | Component tag of that byte |
| byte_idx_o | output | CNT_W | Index of that byte within the active run |

## Verification
Directed patterns come first:
- Codes with every flag combination, which separate correct flag decoding from crossed bit fields.
- Single-bit corruptions of the status byte at each position, which show whether the protection check and bit 7 are actually enforced.
- Broken preambles and repeated FF bytes, which tell preamble locking apart from simple byte matching.
- Start codes with V=1, which show whether the picture region is gated on blanking.

Constrained random lines then mix random payloads, lengths, enable gaps and occasional corrupt codes. These check the Cb/Y/Cr order and the byte numbering across stalls.

// File: rtl/trs_pkg.sv
`timescale 1ns/1ps
package trs_pkg;

    typedef enum logic [2:0] {
        ST_HUNT   = 3'd0,
        ST_GOT_FF = 3'd1,
        ST_GOT_Z1 = 3'd2,
        ST_GOT_Z2 = 3'd3,
        ST_ACTIVE = 3'd4
    } sync_state_t;

    typedef enum logic [1:0] {
        COMP_CB = 2'd0,
        COMP_Y  = 2'd1,
        COMP_CR = 2'd2
    } comp_tag_t;

    localparam int unsigned BYTE_W = 8;
    localparam logic [BYTE_W-1:0] PRE_HI = 8'hFF;
    localparam logic [BYTE_W-1:0] PRE_LO = 8'h00;

    // Protection nibble expected for given flags, MSB first.
    function automatic logic [3:0] prot_bits(input logic f, input logic v, input logic h);
        return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    // Component tag for a position within the four-byte group.
    function automatic comp_tag_t tag_for_phase(input logic [1:0] phase);
        comp_tag_t t;
        unique case (phase)
            2'd0:    t = COMP_CB;
            2'd2:    t = COMP_CR;
            default: t = COMP_Y;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/trs_xy_check.sv
`timescale 1ns/1ps
module trs_xy_check
    import trs_pkg::*;
(
    input  logic [BYTE_W-1:0] xy,
    output logic              code_ok,
    output logic              code_f,
    output logic              code_v,
    output logic              code_h
);

    logic [3:0] want_prot;

    always_comb begin
        code_f    = xy[6];
        code_v    = xy[5];
        code_h    = xy[4];
        want_prot = prot_bits(xy[6], xy[5], xy[4]);
        code_ok   = xy[7] && (xy[3:0] == want_prot);
    end

endmodule

// File: rtl/trs_sync_fsm.sv
`timescale 1ns/1ps
module trs_sync_fsm
    import trs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [BYTE_W-1:0] din,
    input  logic              code_ok,
    input  logic              code_v,
    input  logic              code_h,
    output logic              xy_take,
    output logic              byte_take,
    output logic              enter_active
);

    sync_state_t state_q, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HUNT;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx     = state_q;
        xy_take      = 1'b0;
        byte_take    = 1'b0;
        enter_active = 1'b0;
        if (en) begin
            unique case (state_q)
                ST_HUNT: begin
                    if (din == PRE_HI) state_nx = ST_GOT_FF;
                end
                ST_ACTIVE: begin
                    if (din == PRE_HI) state_nx = ST_GOT_FF;
                    else               byte_take = 1'b1;
                end
                ST_GOT_FF: begin
                    if (din == PRE_LO)      state_nx = ST_GOT_Z1;
                    else if (din == PRE_HI) state_nx = ST_GOT_FF;
                    else                    state_nx = ST_HUNT;
                end
                ST_GOT_Z1: begin
                    if (din == PRE_LO)      state_nx = ST_GOT_Z2;
                    else if (din == PRE_HI) state_nx = ST_GOT_FF;
                    else                    state_nx = ST_HUNT;
                end
                ST_GOT_Z2: begin
                    xy_take = 1'b1;
                    if (code_ok && !code_h && !code_v) begin
                        state_nx     = ST_ACTIVE;
                        enter_active = 1'b1;
                    end else begin
                        state_nx = ST_HUNT;
                    end
                end
                default: state_nx = ST_HUNT;
            endcase
        end
    end

    // R2: the picture state is only entered straight from a full preamble
    assert_active_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && $past(state_q) != ST_ACTIVE) |-> $past(state_q) == ST_GOT_Z2);

    // R9: a disabled cycle leaves the state untouched
    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(state_q));

endmodule

// File: rtl/trs_pixel_tagger.sv
`timescale 1ns/1ps
module trs_pixel_tagger
    import trs_pkg::*;
#(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             byte_take,
    output logic             valid_o,
    output logic [1:0]       comp_o,
    output logic [CNT_W-1:0] idx_o
);

    localparam int unsigned PHASE_W = 2;

    logic [PHASE_W-1:0] phase_q;
    logic [CNT_W-1:0]   cnt_q;
    comp_tag_t          comp_q;
    logic [CNT_W-1:0]   idx_q;
    logic               valid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            cnt_q   <= '0;
            comp_q  <= COMP_CB;
            idx_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= byte_take;
            if (restart) begin
                phase_q <= '0;
                cnt_q   <= '0;
            end else if (byte_take) begin
                comp_q  <= tag_for_phase(phase_q);
                idx_q   <= cnt_q;
                phase_q <= phase_q + 1'b1;
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    assign valid_o = valid_q;
    assign comp_o  = comp_q;
    assign idx_o   = idx_q;

    // R8: a blue-difference tag always falls on a byte number divisible by four
    assert_cb_aligned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && comp_q == COMP_CB) |-> idx_q[1:0] == 2'd0);

endmodule

// File: rtl/trs_stream_decoder.sv
`timescale 1ns/1ps
module trs_stream_decoder
    import trs_pkg::*;
#(
    parameter int unsigned CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [7:0]       din,
    output logic             field_o,
    output logic             vblank_o,
    output logic             hpos_o,
    output logic             line_valid_o,
    output logic             sav_o,
    output logic             eav_o,
    output logic             prot_err_o,
    output logic             active_o,
    output logic [1:0]       comp_o,
    output logic [CNT_W-1:0] byte_idx_o
);

    logic code_ok, code_f, code_v, code_h;
    logic xy_take, byte_take, enter_active;

    logic field_q, vblank_q, hpos_q, line_q;
    logic sav_q, eav_q, err_q;

    trs_xy_check u_xy (
        .xy      (din),
        .code_ok (code_ok),
        .code_f  (code_f),
        .code_v  (code_v),
        .code_h  (code_h)
    );

    trs_sync_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .din          (din),
        .code_ok      (code_ok),
        .code_v       (code_v),
        .code_h       (code_h),
        .xy_take      (xy_take),
        .byte_take    (byte_take),
        .enter_active (enter_active)
    );

    trs_pixel_tagger #(.CNT_W(CNT_W)) u_tag (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (enter_active),
        .byte_take (byte_take),
        .valid_o   (active_o),
        .comp_o    (comp_o),
        .idx_o     (byte_idx_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q  <= 1'b0;
            vblank_q <= 1'b1;
            hpos_q   <= 1'b1;
            line_q   <= 1'b0;
            sav_q    <= 1'b0;
            eav_q    <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            sav_q <= xy_take && code_ok && !code_h;
            eav_q <= xy_take && code_ok && code_h;
            err_q <= xy_take && !code_ok;
            if (xy_take && code_ok) begin
                field_q  <= code_f;
                vblank_q <= code_v;
                hpos_q   <= code_h;
                line_q   <= !code_h && !code_v;
            end
        end
    end

    assign field_o      = field_q;
    assign vblank_o     = vblank_q;
    assign hpos_o       = hpos_q;
    assign line_valid_o = line_q;
    assign sav_o        = sav_q;
    assign eav_o        = eav_q;
    assign prot_err_o   = err_q;

    // R4: a rejected status byte leaves every stored flag as it was
    assert_flags_kept_on_error_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> ($stable(field_q) && $stable(vblank_q) && $stable(hpos_q) && $stable(line_q)));

    // R5: at most one code outcome per cycle
    assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sav_q, eav_q, err_q}));

    // R6: an end code always closes the picture line
    assert_eav_closes_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eav_q |-> (!line_q && hpos_q));

    // R7: picture bytes only appear on a valid line
    assert_active_inside_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> (line_q && !vblank_q && !hpos_q));

endmodule

// File: tb/trs_stream_decoder_tb.sv
`timescale 1ns/1ps
module trs_stream_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 11;
    localparam int WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             en;
    logic [7:0]       din;
    logic             field_o, vblank_o, hpos_o, line_valid_o;
    logic             sav_o, eav_o, prot_err_o, active_o;
    logic [1:0]       comp_o;
    logic [CNT_W-1:0] byte_idx_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit gaps_on  = 0;
    bit done     = 0;

    // expected stored state, updated from the requirements
    logic cur_f, cur_v, cur_h, cur_lv;

    always #(CLK_PERIOD/2) clk = ~clk;

    trs_stream_decoder #(.CNT_W(CNT_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .din          (din),
        .field_o      (field_o),
        .vblank_o     (vblank_o),
        .hpos_o       (hpos_o),
        .line_valid_o (line_valid_o),
        .sav_o        (sav_o),
        .eav_o        (eav_o),
        .prot_err_o   (prot_err_o),
        .active_o     (active_o),
        .comp_o       (comp_o),
        .byte_idx_o   (byte_idx_o)
    );

    function automatic logic [7:0] make_xy(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic int exp_tag(input int i);
        int m;
        m = i % 4;
        if (m == 0) return 0;
        if (m == 2) return 2;
        return 1;
    endfunction

    task automatic chk(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic chk_flags(input string what);
        chk({what, " R3 field"},  field_o,      cur_f);
        chk({what, " R3 vblank"}, vblank_o,     cur_v);
        chk({what, " R3 hpos"},   hpos_o,       cur_h);
        chk({what, " R6 line"},   line_valid_o, cur_lv);
    endtask

    task automatic idle_chk();
        @(negedge clk);
        en  = 1'b0;
        din = 8'($urandom);
        @(posedge clk);
        #1;
        chk("R9 idle active", active_o, 0);
        chk("R9 idle pulses", {sav_o, eav_o, prot_err_o}, 0);
    endtask

    task automatic push(input logic [7:0] b);
        if (gaps_on && ($urandom_range(3) == 0)) idle_chk();
        @(negedge clk);
        en  = 1'b1;
        din = b;
        @(posedge clk);
        #1;
    endtask

    // flip < 0 : good code; otherwise that bit of the status byte is inverted
    task automatic send_code(input logic f, input logic v, input logic h, input int flip);
        logic [7:0] xy;
        xy = make_xy(f, v, h);
        if (flip >= 0) xy[flip] = ~xy[flip];
        push(8'hFF);
        chk("R7 FF not active", active_o, 0);
        push(8'h00);
        push(8'h00);
        push(xy);
        if (flip < 0) begin
            cur_f = f; cur_v = v; cur_h = h; cur_lv = !h && !v;
            chk("R5 sav", sav_o, !h);
            chk("R5 eav", eav_o, h);
            chk("R4 no err", prot_err_o, 0);
        end else begin
            chk("R4 err", prot_err_o, 1);
            chk("R4 no sav/eav", {sav_o, eav_o}, 0);
        end
        chk_flags("code");
        chk("R7 status not active", active_o, 0);
    endtask

    task automatic send_payload(input int n, input bit act);
        for (int i = 0; i < n; i++) begin
            push(8'($urandom_range(254, 1)));
            chk("R7 active", active_o, act);
            if (act) begin
                chk("R8 comp", comp_o, exp_tag(i));
                chk("R8 idx", byte_idx_o, i);
            end
            chk("R2 no stray pulse", {sav_o, eav_o, prot_err_o}, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0656));
        rst_n = 1'b0;
        en    = 1'b0;
        din   = 8'h00;
        cur_f = 0; cur_v = 1; cur_h = 1; cur_lv = 0;
        repeat (4) @(posedge clk);
        #1;
        chk_flags("R1 in reset");
        chk("R1 pulses", {sav_o, eav_o, prot_err_o, active_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk_flags("R1 after reset");
        chk("R1 active", active_o, 0);

        // directed: end code, blanking, start code, picture, end code
        send_code(0, 0, 1, -1);
        send_payload(5, 0);
        send_code(0, 0, 0, -1);
        send_payload(9, 1);
        // stall inside picture keeps the tag sequence going (R9, R8)
        idle_chk();
        push(8'h40);
        chk("R8 after stall active", active_o, 1);
        chk("R8 after stall comp", comp_o, exp_tag(9));
        chk("R8 after stall idx", byte_idx_o, 9);
        send_code(1, 0, 1, -1);
        send_payload(4, 0);

        // R4: every single-bit corruption of the status byte is rejected
        for (int b = 0; b < 8; b++) begin
            send_code(1, 0, 0, b);
            send_payload(3, 0);
        end

        // R6/R7: start code in vertical blanking
        send_code(1, 1, 0, -1);
        send_payload(6, 0);
        send_code(1, 1, 1, -1);

        // R2: broken preamble then a good-looking status byte
        push(8'hFF); push(8'h00); push(8'h12);
        push(make_xy(0, 0, 0));
        chk("R2 broken preamble sav", sav_o, 0);
        chk("R2 broken preamble err", prot_err_o, 0);
        chk_flags("R2 broken");
        // R2: 00 00 without FF
        push(8'h00); push(8'h00); push(make_xy(0, 0, 0));
        chk("R2 no FF sav", sav_o, 0);
        chk_flags("R2 no FF");
        // R2: repeated FF restarts the preamble
        push(8'hFF);
        send_code(0, 0, 0, -1);
        send_payload(4, 1);
        // R7: active run ends at the FF, then an end code
        send_code(0, 0, 1, -1);

        // random lines with enable gaps and occasional corruption
        gaps_on = 1;
        for (int ln = 0; ln < 80; ln++) begin
            logic f, v;
            int ef, sf;
            f  = 1'($urandom);
            v  = ($urandom_range(3) == 0);
            ef = ($urandom_range(7) == 0) ? int'($urandom_range(7)) : -1;
            sf = ($urandom_range(7) == 0) ? int'($urandom_range(7)) : -1;
            send_code(f, v, 1, ef);
            send_payload($urandom_range(8, 2), 0);
            send_code(f, v, 0, sf);
            send_payload($urandom_range(40, 4), (sf < 0) && !v);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule